// File: doc/BRIEF.md
# Edge-Triggered Output Re-Phasing Controller

This controller sits beside a programmable post divider and lets an external synchronisation input re-phase the divided output clock. One edge of the synchronisation input brings the output to a clean halt. The opposite edge restarts the divider from a known phase. The output therefore lines up with the synchronisation input plus a fixed latency.

The enable input turns the feature on. The polarity input chooses which edge of the synchronisation input restarts the clock. The controller never gates the output clock itself. It only drives two controls into the divider: a run/hold level and a one-cycle phase-load pulse. A half-cycle flag accompanies the load pulse. With it, the divider can start on either edge of the fast clock, which gives alignment to half a fast-clock period.

The synchronisation input is sampled on both fast-clock edges and passes through multi-stage synchronisers before edge detection. A level of the synchronisation input that lasts less than the minimum time produces a one-cycle violation pulse. The sequence in progress is not aborted.

Top module: `sync_rephase_ctrl`

## Requirements
- R1: While reset is asserted and right after it, run_o=1, div_rst_o=0, half_o=0 and viol_o=0.
- R2: With sync_en_i=0, changes on sync_i have no effect: run_o stays 1 and div_rst_o and viol_o stay 0.
- R3: With sync_pol_i=1 and the block enabled and running, a falling edge of sync_i starts a stop. Once held, run_o stays 0 whatever div_lvl_i does.
- R4: During a stop, run_o stays 1 as long as div_lvl_i (the divider output level) is 1. run_o falls only while div_lvl_i is 0, so no high pulse is cut short.
- R5: Restart latency is fixed. Suppose sync_i changes to its active level at some point in the interval after rising clock edge p and up to the next one, while the block is held. Then div_rst_o is 1 for exactly the one cycle that starts at rising edge p+SYNC_STAGES+1, and run_o is 1 from that same edge on.
- R6: On a restart, half_o is updated and then held. It becomes 1 if the new level of sync_i arrived before the falling clock edge inside that interval, and 0 if it arrived after it.
- R7: With sync_pol_i=0 the roles are swapped: a rising edge of sync_i stops the output and a falling edge restarts it.
- R8: Let MIN_CYC = MIN_OUT_PERIODS*OUT_RATIO. A level of sync_i that lasts fewer than MIN_CYC clock cycles, ended by a further edge, makes viol_o 1 for one cycle. That cycle is the same one in which a restart caused by that ending edge would show div_rst_o. A level of exactly MIN_CYC cycles raises no violation.
- R9: An edge that does not match the current step of the sequence is ignored. An active edge while running or while stopping does not cause a restart. An inactive edge while held does not disturb the hold.
- R10: Clearing sync_en_i while held returns run_o to 1 on the next clock edge, without a div_rst_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast (VCO-rate) clock; both edges sample sync_i |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | External synchronisation input, asynchronous |
| sync_en_i | input | 1 | 1 enables re-phasing, 0 ignores sync_i |
| sync_pol_i | input | 1 | Active (restart) edge: 1 rising, 0 falling |
| div_lvl_i | input | 1 | Current level of the divided output clock |
| run_o | output | 1 | 1 lets the post divider count, 0 holds it |
| div_rst_o | output | 1 | One-cycle pulse that loads the divider start phase |
| half_o | output | 1 | Divider should start on the falling fast-clock edge |
| viol_o | output | 1 | One-cycle pulse: sync_i level shorter than the minimum |

## Verification
The bench builds the block with two synchroniser stages, four fast cycles per output period and a three-period minimum. The minimum pulse is then 12 cycles. Both the exact-minimum boundary and short pulses of four and five cycles can be reached within a few dozen cycles. Sync changes are placed just after a rising edge and just after a falling edge. This shows that both halves give the same restart cycle and opposite half flags, under both polarities.

// File: rtl/sync_rephase_pkg.sv
package sync_rephase_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_STOP = 2'd1,
      ST_HELD = 2'd2
   } seq_state_t;

endpackage

// File: rtl/sync_rephase_sampler.sv
// Dual-edge synchroniser and polarity-aware edge detector.
module sync_rephase_sampler #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sync_i,
   input  logic pol_i,
   output logic act_edge_o,
   output logic inact_edge_o,
   output logic any_edge_o,
   output logic early_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sync_rephase_sampler: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] rise_q;
   logic [STAGES-1:0] fall_q;
   logic              fall_rt_q;
   logic              prev_q;
   logic              late_s;
   logic              early_s;

   // rising-edge chain: holds the sample taken STAGES cycles ago
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rise_q <= '0;
      else         rise_q <= {rise_q[STAGES-2:0], sync_i};
   end

   // falling-edge chain, retimed once so it pairs with the half cycle before
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fall_q <= '0;
      else         fall_q <= {fall_q[STAGES-2:0], sync_i};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fall_rt_q <= 1'b0;
         prev_q    <= 1'b0;
      end else begin
         fall_rt_q <= fall_q[STAGES-1];
         prev_q    <= late_s;
      end
   end

   assign late_s  = rise_q[STAGES-1];
   assign early_s = fall_rt_q;

   assign act_edge_o   = (prev_q != pol_i) && (late_s == pol_i);
   assign inact_edge_o = (prev_q == pol_i) && (late_s != pol_i);
   assign any_edge_o   = prev_q != late_s;
   assign early_o      = early_s == pol_i;

endmodule

// File: rtl/sync_rephase_pulse_chk.sv
// Measures each sync level and flags the ones below the minimum.
module sync_rephase_pulse_chk #(
   parameter int MIN_CYC = 12
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic edge_i,
   output logic viol_o
);

   localparam int CW = $clog2(MIN_CYC + 1);
   localparam logic [CW-1:0] MIN_V = CW'(MIN_CYC);

   generate
      if (MIN_CYC < 2) begin : g_bad_min
         $error("sync_rephase_pulse_chk: MIN_CYC must be at least 2");
      end
   endgenerate

   logic [CW-1:0] len_q;
   logic          viol_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         len_q  <= MIN_V;
         viol_q <= 1'b0;
      end else begin
         viol_q <= en_i && edge_i && (len_q < MIN_V);
         if (edge_i)            len_q <= CW'(1);
         else if (len_q < MIN_V) len_q <= len_q + 1'b1;
      end
   end

   assign viol_o = viol_q;

   AST_VIOL_AFTER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      viol_q |-> $past(edge_i)); // R8

endmodule

// File: rtl/sync_rephase_seq.sv
// Stop / hold / restart sequencer driving the post divider.
module sync_rephase_seq
   import sync_rephase_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic act_edge_i,
   input  logic inact_edge_i,
   input  logic early_i,
   input  logic div_lvl_i,
   output logic run_o,
   output logic div_rst_o,
   output logic half_o
);

   seq_state_t state_q;
   logic       div_rst_q;
   logic       half_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_RUN;
         div_rst_q <= 1'b0;
         half_q    <= 1'b0;
      end else begin
         div_rst_q <= 1'b0;
         if (!en_i) begin
            state_q <= ST_RUN;
         end else begin
            unique case (state_q)
               ST_RUN:  if (inact_edge_i) state_q <= ST_STOP;
               ST_STOP: if (!div_lvl_i)   state_q <= ST_HELD;
               ST_HELD: if (act_edge_i) begin
                  state_q   <= ST_RUN;
                  div_rst_q <= 1'b1;
                  half_q    <= early_i;
               end
               default: state_q <= ST_RUN;
            endcase
         end
      end
   end

   // during a stop the divider keeps counting until its output is low
   assign run_o     = (state_q == ST_RUN) || ((state_q == ST_STOP) && div_lvl_i);
   assign div_rst_o = div_rst_q;
   assign half_o    = half_q;

   AST_DISABLED_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (state_q == ST_RUN) && !div_rst_q); // R2

   AST_LOAD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_rst_q |=> !div_rst_q); // R5

   AST_LOAD_FROM_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(div_rst_q) |-> $past(state_q) == ST_HELD); // R9

   AST_HOLD_AT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(state_q == ST_HELD) |-> !$past(div_lvl_i)); // R4

endmodule

// File: rtl/sync_rephase_ctrl.sv
module sync_rephase_ctrl #(
   parameter int SYNC_STAGES     = 2,
   parameter int OUT_RATIO       = 4,
   parameter int MIN_OUT_PERIODS = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sync_i,
   input  logic sync_en_i,
   input  logic sync_pol_i,
   input  logic div_lvl_i,
   output logic run_o,
   output logic div_rst_o,
   output logic half_o,
   output logic viol_o
);

   localparam int MIN_CYC = OUT_RATIO * MIN_OUT_PERIODS;

   generate
      if (OUT_RATIO < 1 || MIN_OUT_PERIODS < 1) begin : g_bad_ratio
         $error("sync_rephase_ctrl: OUT_RATIO and MIN_OUT_PERIODS must be positive");
      end
   endgenerate

   logic act_edge;
   logic inact_edge;
   logic any_edge;
   logic early;

   sync_rephase_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sync_i       (sync_i),
      .pol_i        (sync_pol_i),
      .act_edge_o   (act_edge),
      .inact_edge_o (inact_edge),
      .any_edge_o   (any_edge),
      .early_o      (early)
   );

   sync_rephase_pulse_chk #(.MIN_CYC(MIN_CYC)) u_pulse_chk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (sync_en_i),
      .edge_i (any_edge),
      .viol_o (viol_o)
   );

   sync_rephase_seq u_seq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (sync_en_i),
      .act_edge_i   (act_edge),
      .inact_edge_i (inact_edge),
      .early_i      (early),
      .div_lvl_i    (div_lvl_i),
      .run_o        (run_o),
      .div_rst_o    (div_rst_o),
      .half_o       (half_o)
   );

endmodule

// File: tb/sync_rephase_ctrl_tb.sv
module sync_rephase_ctrl_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_in = 1'b0;
   logic en = 1'b0;
   logic pol = 1'b1;
   logic lvl = 1'b0;
   logic run, div_rst, half, viol;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   sync_rephase_ctrl #(.SYNC_STAGES(2), .OUT_RATIO(4), .MIN_OUT_PERIODS(3)) u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .sync_i     (sync_in),
      .sync_en_i  (en),
      .sync_pol_i (pol),
      .div_lvl_i  (lvl),
      .run_o      (run),
      .div_rst_o  (div_rst),
      .half_o     (half),
      .viol_o     (viol)
   );

   typedef struct packed {
      logic [3:0] req;
      logic       en, pol, snc, lvl, late;
      logic [4:0] n;
      logic       run, rst, half, viol;
   } vec_t;

   // drive just after a rising edge (late=0: before the falling edge,
   // late=1: after it), wait n rising edges, sample 2 ns later
   localparam int NV = 26;
   localparam vec_t VEC [NV] = '{
      '{2, 0,1,1,1,0,  3, 1,0,0,0},  // R2 rising sync ignored while disabled
      '{2, 0,1,0,1,0,  3, 1,0,0,0},  // R2 short pulse, no violation while disabled
      '{1, 1,1,0,1,0, 15, 1,0,0,0},  // R1 enabling at the inactive level changes nothing
      '{9, 1,1,1,1,0,  3, 1,0,0,0},  // R9 active edge while running: no load
      '{9, 1,1,1,1,0, 12, 1,0,0,0},  // R9 still running
      '{4, 1,1,0,1,0,  3, 1,0,0,0},  // R4 stop requested, divider output high
      '{3, 1,1,0,0,0,  0, 0,0,0,0},  // R3 divider output low: hold
      '{3, 1,1,0,0,0,  3, 0,0,0,0},  // R3 held
      '{3, 1,1,0,1,0,  2, 0,0,0,0},  // R3 held regardless of divider level
      '{5, 1,1,1,1,0,  3, 1,1,1,0},  // R5 R6 R8 restart, early half, 12-cycle low ok
      '{5, 1,1,1,1,0,  0, 1,0,1,0},  // R5 load lasts one cycle
      '{8, 1,1,0,0,1,  3, 0,0,1,1},  // R8 5-cycle high flagged, stop still done
      '{3, 1,1,0,0,0, 14, 0,0,1,0},  // R3 held
      '{6, 1,1,1,0,1,  3, 1,1,0,0},  // R6 restart, late half
      '{7, 1,0,1,0,0, 14, 1,0,0,0},  // R7 polarity swap, steady level
      '{7, 1,0,0,0,0,  3, 1,0,0,0},  // R7 falling edge while running: no load
      '{7, 1,0,0,0,0,  9, 1,0,0,0},  // R7 running
      '{7, 1,0,1,0,0,  3, 0,0,0,0},  // R7 rising edge stops
      '{7, 1,0,1,0,0, 13, 0,0,0,0},  // R7 held
      '{7, 1,0,0,0,0,  3, 1,1,1,0},  // R7 falling edge restarts, early half
      '{9, 1,0,0,1,0, 13, 1,0,1,0},  // R9 running
      '{4, 1,0,1,1,0,  3, 1,0,1,0},  // R4 stopping, divider high keeps running
      '{9, 1,0,0,1,0,  3, 1,0,1,1},  // R9 R8 short active edge: flagged, no load
      '{9, 1,0,0,0,0,  3, 0,0,1,0},  // R9 stop completes, no restart
      '{9, 1,0,0,0,0, 13, 0,0,1,0},  // R9 remains held
      '{10,0,0,0,0,0,  3, 1,0,1,0}   // R10 disable while held releases
   };

   task automatic check(input int req, input int idx, input string what,
                        input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL R%0d step %0d %s actual=%0b expected=%0b", req, idx, what, act, exp);
      end
   endtask

   task automatic check_all(input int req, input int idx, input logic e_run,
                            input logic e_rst, input logic e_half, input logic e_viol);
      check(req, idx, "run", run, e_run);
      check(req, idx, "div_rst", div_rst, e_rst);
      check(req, idx, "half", half, e_half);
      check(req, idx, "viol", viol, e_viol);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(posedge clk);
      #2;
      check_all(1, -1, 1'b1, 1'b0, 1'b0, 1'b0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #2;
      check_all(1, -2, 1'b1, 1'b0, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VEC[i];
         @(posedge clk);
         if (v.late) #5; else #1;
         en = v.en; pol = v.pol; sync_in = v.snc; lvl = v.lvl;
         repeat (int'(v.n)) @(posedge clk);
         #2;
         check_all(int'(v.req), i, v.run, v.rst, v.half, v.viol);
      end

      // R7 stop again with falling-edge polarity, then R1 reset mid-hold
      @(posedge clk); #1 en = 1'b1;
      repeat (14) @(posedge clk);
      #1 sync_in = 1'b1;
      repeat (4) @(posedge clk);
      #2;
      check(7, 100, "run", run, 1'b0);
      rst_n = 1'b0;
      #1;
      check_all(1, 101, 1'b1, 1'b0, 1'b0, 1'b0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule